// File: doc/BRIEF.md
# DRAM Strobe Mode Decoder

This block sits on the device side of an asynchronous DRAM interface with two byte lanes. It samples the row strobe, the two lane column strobes, write enable and output enable on a fast system clock. From the order in which the strobes change, it works out what each row-strobe-low period was. The possible outcomes are a row-address-only refresh, a column-before-row refresh, a hidden refresh, a byte or word read, an early write or a late (read-modify) write.

The decoder latches the row address and the column address for a memory-array model. It also drives a per-lane output enable and a one-cycle per-lane write strobe. It keeps an internal refresh row counter, which supplies the row whenever a refresh takes its row from the device rather than from the address pins. When the row strobe returns high, a one-cycle valid pulse reports a 3-bit code that classifies the period just ended.

All strobe inputs are active low. Each output is registered and reflects the inputs sampled on the same rising clock edge.

Top module: `dram_strobe_decoder`

## Requirements
- R1: While the row strobe is high and both column strobes are high, both lane output enables (`drv_lo`, `drv_hi`) are 0, whatever `we_n` and `oe_n` are.
- R2: A row-strobe fall with both column strobes high latches `addr` into `row_q`. If no column strobe falls before the row strobe rises again, the period reports mode 1 (row-address-only refresh), and no lane is driven or strobed during it.
- R3: A row-strobe fall sampled while either column strobe is low is a column-before-row refresh. `row_q` takes the refresh counter value, `addr` is ignored, no lane is driven or strobed, and the period reports mode 2.
- R4: A column-before-row refresh entered while a column strobe has been held low since an access period is a hidden refresh. It reports mode 3, uses the counter for `row_q`, and keeps the previous read lanes driven through the row-strobe high and low phases while `oe_n` stays low.
- R5: In an access period, a lane whose column strobe falls with `we_n` high becomes a read lane. It is driven (`drv_lo` is bit 0, `drv_hi` is bit 1) while its column strobe is low and `oe_n` is low. A period with only reads reports mode 5 if both lanes were strobed, and mode 4 otherwise.
- R6: `wstb_lo`/`wstb_hi` pulse for one cycle when a lane's column strobe and `we_n` first become low together in an access period. `col_q` is latched only at the earlier column-strobe fall after both strobes were high. A period with `we_n` low at that fall reports mode 6.
- R7: `we_n` falling while a column strobe is already held low is a late write. The lane keeps driving read data while `oe_n` is low before the fall. The period reports mode 7, which takes priority over mode 6 when both occur in one period.
- R8: The refresh counter (`refresh_row`) resets to 0. It increments by one at the end of every mode 2 or mode 3 period, wraps from 1023 to 0, and is otherwise unchanged.
- R9: `mode_vld` is high for exactly the one cycle that follows the sample in which the row strobe is seen rising, and `mode` then carries the code. Code 0 is standby and is never reported.
- R10: During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| row_q | output | AW | Row latched at row-strobe fall (address or counter) |
| col_q | output | AW | Column latched at the earlier column-strobe fall |
| refresh_row | output | AW | Internal refresh row counter |
| drv_lo | output | 1 | Lower lane output enable |
| drv_hi | output | 1 | Upper lane output enable |
| wstb_lo | output | 1 | Lower lane write strobe, one cycle |
| wstb_hi | output | 1 | Upper lane write strobe, one cycle |
| mode_vld | output | 1 | One-cycle pulse when a period ends |
| mode | output | 3 | Code of the period just ended |

## Verification
The checker watches, on every cycle, these properties:
- the lanes stay undriven in standby and whenever output enable is high;
- a write strobe never appears on a lane whose column strobe is high, and it never lasts two cycles;
- the report pulse follows each row-strobe rise for exactly one cycle;
- the refresh counter moves by exactly one, and only when a refresh is reported.

The bench scenarios are the only way to show several other behaviours:
- which mode a period is given, including the priority of a late write over an early one in one page;
- that the column is taken at the earlier of two staggered strobe falls;
- that a refresh takes the counter row and ignores the address;
- that the read lanes stay driven across a hidden refresh;
- that the counter wraps after 1024 refreshes.

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          lcas_n,
  input  logic          ucas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] row_q,
  output logic [AW-1:0] col_q,
  output logic [AW-1:0] refresh_row,
  output logic          drv_lo,
  output logic          drv_hi,
  output logic          wstb_lo,
  output logic          wstb_hi,
  output logic          mode_vld,
  output logic [2:0]    mode
);
  localparam logic [2:0] M_ROWREF = 3'd1, M_CBR = 3'd2, M_HIDDEN = 3'd3,
                         M_RD_BYTE = 3'd4, M_RD_WORD = 3'd5,
                         M_WR_EARLY = 3'd6, M_WR_LATE = 3'd7;
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic ras_q, lcas_q, ucas_q, we_q;
  logic in_rfsh, in_hid, hold;
  logic f_lo, f_hi, f_early, f_late;
  logic rd_lo, rd_hi, rd_lo_nx, rd_hi_nx;
  logic [2:0] mode_nx;

  wire ras_fall  = ras_q & ~ras_n;
  wire ras_rise  = ~ras_q & ras_n;
  wire cas_any   = ~lcas_n | ~ucas_n;
  wire cas_any_q = ~lcas_q | ~ucas_q;
  wire acc_now   = ~ras_n & (ras_fall ? ~cas_any : ~in_rfsh);
  wire grp_start = acc_now & cas_any & ~cas_any_q;
  wire lo_fall   = acc_now & ~lcas_n & lcas_q;
  wire hi_fall   = acc_now & ~ucas_n & ucas_q;
  wire late_we   = acc_now & cas_any & cas_any_q & we_q & ~we_n;
  wire wlo_now   = acc_now & ~lcas_n & ~we_n;
  wire whi_now   = acc_now & ~ucas_n & ~we_n;

  always_comb begin
    rd_lo_nx = rd_lo;
    if (lcas_n)       rd_lo_nx = 1'b0;
    else if (lo_fall) rd_lo_nx = we_n;
    rd_hi_nx = rd_hi;
    if (ucas_n)       rd_hi_nx = 1'b0;
    else if (hi_fall) rd_hi_nx = we_n;
  end

  always_comb begin
    if (in_rfsh)               mode_nx = in_hid ? M_HIDDEN : M_CBR;
    else if (!(f_lo || f_hi))  mode_nx = M_ROWREF;
    else if (f_late)           mode_nx = M_WR_LATE;
    else if (f_early)          mode_nx = M_WR_EARLY;
    else if (f_lo && f_hi)     mode_nx = M_RD_WORD;
    else                       mode_nx = M_RD_BYTE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q <= 1'b1; lcas_q <= 1'b1; ucas_q <= 1'b1; we_q <= 1'b1;
      in_rfsh <= 1'b0; in_hid <= 1'b0; hold <= 1'b0;
      f_lo <= 1'b0; f_hi <= 1'b0; f_early <= 1'b0; f_late <= 1'b0;
      rd_lo <= 1'b0; rd_hi <= 1'b0;
      row_q <= '0; col_q <= '0; refresh_row <= '0;
      drv_lo <= 1'b0; drv_hi <= 1'b0; wstb_lo <= 1'b0; wstb_hi <= 1'b0;
      mode_vld <= 1'b0; mode <= 3'd0;
    end else begin
      ras_q <= ras_n; lcas_q <= lcas_n; ucas_q <= ucas_n; we_q <= we_n;
      rd_lo <= rd_lo_nx;
      rd_hi <= rd_hi_nx;
      drv_lo <= rd_lo_nx & ~lcas_n & ~oe_n;
      drv_hi <= rd_hi_nx & ~ucas_n & ~oe_n;
      wstb_lo <= wlo_now & (lcas_q | we_q);
      wstb_hi <= whi_now & (ucas_q | we_q);

      if (!cas_any)       hold <= 1'b0;
      else if (grp_start) hold <= 1'b1;

      if (ras_fall) begin
        in_rfsh <= cas_any;
        in_hid  <= cas_any & hold;
        row_q   <= cas_any ? refresh_row : addr;
        f_lo <= 1'b0; f_hi <= 1'b0; f_early <= 1'b0; f_late <= 1'b0;
      end else begin
        if (lo_fall) f_lo <= 1'b1;
        if (hi_fall) f_hi <= 1'b1;
        if (grp_start && !we_n) f_early <= 1'b1;
        if (late_we) f_late <= 1'b1;
      end

      if (grp_start) col_q <= addr;

      mode_vld <= ras_rise;
      if (ras_rise) begin
        mode <= mode_nx;
        if (in_rfsh) refresh_row <= refresh_row + ONE;
      end
    end
  end
endmodule

// File: rtl/dram_strobe_decoder_chk.sv
module dram_strobe_decoder_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          lcas_n,
  input logic          ucas_n,
  input logic          oe_n,
  input logic [AW-1:0] refresh_row,
  input logic          drv_lo,
  input logic          drv_hi,
  input logic          wstb_lo,
  input logic          wstb_hi,
  input logic          mode_vld,
  input logic [2:0]    mode
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  assert_standby_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && lcas_n && ucas_n) |=> (!drv_lo && !drv_hi));

  assert_oe_gates_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> (!drv_lo && !drv_hi));

  assert_lo_strobe_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lcas_n |=> !wstb_lo);

  assert_hi_strobe_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ucas_n |=> !wstb_hi);

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wstb_lo || wstb_hi) |=> !($past(wstb_lo) && wstb_lo) && !($past(wstb_hi) && wstb_hi));

  assert_report_follows_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> mode_vld);

  assert_report_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_vld |=> !mode_vld);

  assert_report_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_vld |-> (mode != 3'd0));

  assert_counter_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_vld && (mode == 3'd2 || mode == 3'd3)) |-> (refresh_row == $past(refresh_row) + ONE));

  assert_counter_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_vld && (mode == 3'd2 || mode == 3'd3)) |-> $stable(refresh_row));
endmodule

bind dram_strobe_decoder dram_strobe_decoder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
  .oe_n(oe_n), .refresh_row(refresh_row), .drv_lo(drv_lo), .drv_hi(drv_hi),
  .wstb_lo(wstb_lo), .wstb_hi(wstb_hi), .mode_vld(mode_vld), .mode(mode));

// File: tb/test_dram_strobe_decoder.sv
module test_dram_strobe_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] row_q, col_q, refresh_row;
  logic drv_lo, drv_hi, wstb_lo, wstb_hi, mode_vld;
  logic [2:0] mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [AW-1:0] exp_cnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_strobe_decoder #(.AW(AW)) i_dram_strobe_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .row_q(row_q), .col_q(col_q),
    .refresh_row(refresh_row), .drv_lo(drv_lo), .drv_hi(drv_hi),
    .wstb_lo(wstb_lo), .wstb_hi(wstb_hi), .mode_vld(mode_vld), .mode(mode));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_mode(input int kind, input logic [1:0] ln);
    if (kind == 2) return 7;
    if (kind == 1) return 6;
    return (ln == 2'b11) ? 5 : 4;
  endfunction

  function automatic int drv2();
    return int'({drv_hi, drv_lo});
  endfunction

  function automatic int wstb2();
    return int'({wstb_hi, wstb_lo});
  endfunction

  task automatic check_report(input int m, input string req);
    chk(mode_vld && int'(mode) == m, req, int'(mode), m);
  endtask

  // kind: 0 read, 1 early write, 2 late write; keep holds CAS low after RAS rises
  task automatic access(input logic [1:0] ln, input int kind,
                        input logic [AW-1:0] row, input logic [AW-1:0] col, input bit keep);
    addr = row; ras_n = 1'b0; tick();
    chk(row_q == row, "R2 row latch", int'(row_q), int'(row));
    addr = col; we_n = (kind == 1) ? 1'b0 : 1'b1; oe_n = (kind == 1) ? 1'b1 : 1'b0;
    lcas_n = ~ln[0]; ucas_n = ~ln[1]; tick();
    chk(col_q == col, "R6 column latch", int'(col_q), int'(col));
    if (kind == 1) begin
      chk(wstb2() == int'(ln), "R6 early strobe", wstb2(), int'(ln));
      chk(drv2() == 0, "R6 no drive on write", drv2(), 0);
    end else begin
      chk(drv2() == int'(ln), "R5 read lanes", drv2(), int'(ln));
      chk(wstb2() == 0, "R5 no strobe on read", wstb2(), 0);
    end
    tick();
    chk(wstb2() == 0, "R6 strobe one cycle", wstb2(), 0);
    if (kind == 2) begin
      chk(drv2() == int'(ln), "R7 read data before write", drv2(), int'(ln));
      oe_n = 1'b1; we_n = 1'b0; tick();
      chk(wstb2() == int'(ln), "R7 late strobe", wstb2(), int'(ln));
      chk(drv2() == 0, "R7 released with oe high", drv2(), 0);
      tick();
    end
    if (!keep) begin
      lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick();
      chk(drv2() == 0, "R5 cas high released", drv2(), 0);
    end
    ras_n = 1'b1; tick();
    check_report(exp_mode(kind, ln), "R9 access report");
    chk(refresh_row == exp_cnt, "R8 counter held", int'(refresh_row), int'(exp_cnt));
    tick();
    chk(!mode_vld, "R9 pulse width", int'(mode_vld), 0);
    if (!keep) chk(drv2() == 0, "R1 standby hiz", drv2(), 0);
  endtask

  task automatic row_only(input logic [AW-1:0] row);
    addr = row; ras_n = 1'b0; tick();
    chk(row_q == row, "R2 refresh row", int'(row_q), int'(row));
    oe_n = 1'b0; we_n = 1'b0; tick();
    chk(drv2() == 0 && wstb2() == 0, "R2 quiet lanes", drv2() + wstb2(), 0);
    ras_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; tick();
    check_report(1, "R2 mode");
    chk(refresh_row == exp_cnt, "R2 counter held", int'(refresh_row), int'(exp_cnt));
    tick();
  endtask

  task automatic cbr(input logic [1:0] ln, input bit quiet);
    lcas_n = ~ln[0]; ucas_n = ~ln[1]; oe_n = 1'b0; tick();
    if (!quiet) chk(drv2() == 0, "R3 no drive", drv2(), 0);
    addr = AW'($urandom); ras_n = 1'b0; tick();
    if (!quiet) chk(row_q == exp_cnt, "R3 counter row, address ignored", int'(row_q), int'(exp_cnt));
    tick();
    if (!quiet) chk(drv2() == 0 && wstb2() == 0, "R3 quiet lanes", drv2() + wstb2(), 0);
    ras_n = 1'b1; tick();
    exp_cnt = exp_cnt + 1'b1;
    if (!quiet) begin
      check_report(2, "R3 mode");
      chk(refresh_row == exp_cnt, "R8 counter step", int'(refresh_row), int'(exp_cnt));
    end
    lcas_n = 1'b1; ucas_n = 1'b1; oe_n = 1'b1; tick();
  endtask

  task automatic hidden(input logic [1:0] ln);
    access(ln, 0, AW'($urandom), AW'($urandom), 1'b1);
    chk(drv2() == int'(ln), "R4 drive kept with ras high", drv2(), int'(ln));
    addr = AW'($urandom); ras_n = 1'b0; tick();
    chk(row_q == exp_cnt, "R4 counter row", int'(row_q), int'(exp_cnt));
    chk(drv2() == int'(ln), "R4 drive kept in refresh", drv2(), int'(ln));
    tick();
    ras_n = 1'b1; tick();
    exp_cnt = exp_cnt + 1'b1;
    check_report(3, "R4 mode");
    chk(refresh_row == exp_cnt, "R8 counter step hidden", int'(refresh_row), int'(exp_cnt));
    tick();
    chk(drv2() == int'(ln), "R4 drive after refresh", drv2(), int'(ln));
    lcas_n = 1'b1; ucas_n = 1'b1; oe_n = 1'b1; tick();
    chk(drv2() == 0, "R1 released", drv2(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) tick();
    chk(row_q == 0 && col_q == 0 && refresh_row == 0 && drv2() == 0 && wstb2() == 0
        && !mode_vld && mode == 0, "R10 reset state", int'(refresh_row), 0);
    rst_n = 1'b1; tick();

    oe_n = 1'b0; tick();
    chk(drv2() == 0, "R1 standby with oe low", drv2(), 0);
    oe_n = 1'b1; tick();

    row_only(10'h155);
    access(2'b01, 0, 10'h012, 10'h034, 1'b0);
    access(2'b11, 0, 10'h3ff, 10'h000, 1'b0);
    access(2'b10, 1, 10'h0aa, 10'h2c1, 1'b0);
    access(2'b11, 2, 10'h100, 10'h201, 1'b0);
    cbr(2'b01, 1'b0);
    cbr(2'b10, 1'b0);
    hidden(2'b11);

    // staggered read: column taken at the earlier strobe fall
    addr = 10'h050; ras_n = 1'b0; tick();
    addr = 10'h111; oe_n = 1'b0; lcas_n = 1'b0; tick();
    addr = 10'h222; ucas_n = 1'b0; tick();
    chk(col_q == 10'h111, "R6 earlier strobe column", int'(col_q), 'h111);
    chk(drv2() == 3, "R5 word read", drv2(), 3);
    lcas_n = 1'b1; ucas_n = 1'b1; oe_n = 1'b1; tick();
    ras_n = 1'b1; tick();
    check_report(5, "R5 word mode");
    tick();

    // page: early write on lower lane, then late write on upper lane
    addr = 10'h060; ras_n = 1'b0; tick();
    addr = 10'h001; we_n = 1'b0; lcas_n = 1'b0; tick();
    chk(wstb2() == 1, "R6 page early strobe", wstb2(), 1);
    lcas_n = 1'b1; we_n = 1'b1; tick();
    addr = 10'h002; oe_n = 1'b0; ucas_n = 1'b0; tick();
    chk(col_q == 10'h002, "R6 page column", int'(col_q), 2);
    chk(drv2() == 2, "R7 upper read data", drv2(), 2);
    oe_n = 1'b1; we_n = 1'b0; tick();
    chk(wstb2() == 2, "R7 page late strobe", wstb2(), 2);
    ucas_n = 1'b1; we_n = 1'b1; tick();
    ras_n = 1'b1; tick();
    check_report(7, "R7 late over early priority");
    tick();

    for (int i = 0; i < 300; i++) begin
      int op;
      logic [1:0] ln;
      op = $urandom_range(0, 5);
      ln = 2'($urandom_range(1, 3));
      case (op)
        0, 1: access(ln, 0, AW'($urandom), AW'($urandom), 1'b0);
        2: access(ln, 1, AW'($urandom), AW'($urandom), 1'b0);
        3: access(ln, 2, AW'($urandom), AW'($urandom), 1'b0);
        4: row_only(AW'($urandom));
        default: if (ln[0]) cbr(ln, 1'b0); else hidden(ln);
      endcase
    end

    // wrap: refresh until the counter passes 1023
    while (exp_cnt != '1) cbr(2'b11, 1'b1);
    chk(refresh_row == 10'h3ff, "R8 counter at top", int'(refresh_row), 1023);
    cbr(2'b11, 1'b0);
    chk(refresh_row == 0, "R8 counter wrap", int'(refresh_row), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule